// File: doc/BRIEF.md
# Multi-Source Interrupt Combiner with Set/Clear Enable and Mask Ports

This block gathers up to sixteen interrupt lines from a board and presents one level-sensitive request line to a parent processor input. Each source passes through a two-flop synchronizer. An enabled source that rises latches a pending bit. The pending bit stays set until software acknowledges it by writing a one to that bit.

Software reaches the block through a small synchronous register port: byte address, write strobe, write data and combinational read data. The registers are 16 bits wide and sit on a 4-byte stride. The enable state and the mask state are never written directly. Each has one address that sets bits where the written word has ones, and a second address that clears them; both addresses read back the current state. A read-only register gives the index of the lowest-numbered pending source that is enabled and unmasked, so a handler can service sources in index order without scanning the status word.

Register map (byte addresses): 0x00 status, 0x04 enable-set, 0x08 enable-clear, 0x0C unmask-set, 0x10 unmask-clear (writing it masks), 0x14 first-active.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the status, enable and unmask state are all zero, every register reads 0x0000, and `irq_o` is low.
- R2: A write to 0x04 sets each enable bit whose data bit is 1 and leaves bits written 0 unchanged. Reads of both 0x04 and 0x08 return the enable state.
- R3: A write to 0x08 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to 0x0C unmasks (sets) each bit written 1. A write to 0x10 masks (clears) each bit written 1. Reads of both addresses return the unmask state, where 1 means unmasked. Masking leaves the status bits unchanged.
- R5: Suppose source n is low at clock edge k-1, is high at edge k, and its enable bit is set at edge k+2. Then status bit n reads 1 after edge k+2 and not earlier. A disabled source, or a source held at a steady level, sets no status bit.
- R6: A write to 0x00 clears each status bit written 1. Bits written 0 have no effect.
- R7: If a rising edge is captured in the same cycle that software acknowledges the same bit, the status bit ends up set.
- R8: `irq_o` equals, one clock later, the OR over all bits of status AND enable AND unmask. It stays high until every such bit is acknowledged, masked or disabled.
- R9: A read of 0x14 returns the lowest index n with status, enable and unmask all set. The index is in bits [3:0] and bit 15 is a valid flag. The register reads 0x0000 when there is no such n.
- R10: Reads of unmapped or misaligned addresses return 0. Writes to those addresses, and writes to 0x14, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source lines, bit n is source n |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, valid in the same cycle |
| irq_o | output | 1 | Registered level-sensitive combined request |

## Verification
The bench builds the block with its defaults: sixteen sources, 16-bit data and a 6-bit address. With sixteen sources every bit of the data word, bit 15 included, is a live source bit. The 6-bit address also leaves unmapped word addresses above 0x14 and misaligned byte addresses that the bench can reach. The bench places source edges so that a capture falls in the same cycle as an acknowledge of that bit. It uses masking and disabling to show that the request line and the first-active register ignore pending bits that are not both enabled and unmasked.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;

  localparam int REG_STRIDE = 4;

  typedef enum logic [2:0] {
    SLOT_STATUS  = 3'd0,
    SLOT_EN_SET  = 3'd1,
    SLOT_EN_CLR  = 3'd2,
    SLOT_UNM_SET = 3'd3,
    SLOT_UNM_CLR = 3'd4,
    SLOT_FIRST   = 3'd5,
    SLOT_NONE    = 3'd7
  } slot_e;

  // Map a byte address to a register slot; misaligned or unmapped -> NONE.
  function automatic slot_e decode_slot(input logic [31:0] byte_addr);
    logic [31:0] word;
    if (byte_addr % REG_STRIDE != 0) return SLOT_NONE;
    word = byte_addr / REG_STRIDE;
    case (word)
      32'd0:   return SLOT_STATUS;
      32'd1:   return SLOT_EN_SET;
      32'd2:   return SLOT_EN_CLR;
      32'd3:   return SLOT_UNM_SET;
      32'd4:   return SLOT_UNM_CLR;
      32'd5:   return SLOT_FIRST;
      default: return SLOT_NONE;
    endcase
  endfunction

  // Slot owns the enable state (either of its two addresses).
  function automatic logic is_enable_slot(input slot_e s);
    return (s == SLOT_EN_SET) || (s == SLOT_EN_CLR);
  endfunction

  // Slot owns the unmask state (either of its two addresses).
  function automatic logic is_unmask_slot(input slot_e s);
    return (s == SLOT_UNM_SET) || (s == SLOT_UNM_CLR);
  endfunction

endpackage

// File: rtl/irqagg_sync.sv
`timescale 1ns/1ps
module irqagg_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        safe_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        safe_q[g] <= meta_q[g];
        prev_q[g] <= safe_q[g];
      end
    end
    assign rise_o[g] = safe_q[g] & ~prev_q[g];
  end

endmodule

// File: rtl/irqagg_bitreg.sv
`timescale 1ns/1ps
module irqagg_bitreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_i) & ~clr_i;
  end

  assign q_o = q;

endmodule

// File: rtl/irqagg_pend.sv
`timescale 1ns/1ps
module irqagg_pend #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cap_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend;

  // Capture is applied after the acknowledge, so capture wins on a tie.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack_i) | cap_i;
  end

  assign pend_o = pend;

endmodule

// File: rtl/irqagg_prio.sv
`timescale 1ns/1ps
module irqagg_prio #(
  parameter int W     = 16,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  // Scan from the top down so that the lowest set bit is written last.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irqagg_top.sv
`timescale 1ns/1ps
module irqagg_top #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  import irqagg_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Decoded access
  slot_e              slot;
  logic [NUM_SRC-1:0] wbits;
  logic               en_touch;
  logic               unm_touch;

  // Named internal events (used by the checker)
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] cap_vec;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] en_set, en_clr, unm_set, unm_clr;
  logic [NUM_SRC-1:0] en_q, unm_q, pend_q;
  logic [NUM_SRC-1:0] active_vec;
  logic               first_valid;
  logic [IDX_W-1:0]   first_idx;
  logic               irq_q;

  assign slot      = decode_slot({{(32-ADDR_W){1'b0}}, bus_addr});
  assign wbits     = bus_wdata[NUM_SRC-1:0];
  assign en_touch  = bus_we && is_enable_slot(slot);
  assign unm_touch = bus_we && is_unmask_slot(slot);

  assign en_set  = (bus_we && slot == SLOT_EN_SET)  ? wbits : '0;
  assign en_clr  = (bus_we && slot == SLOT_EN_CLR)  ? wbits : '0;
  assign unm_set = (bus_we && slot == SLOT_UNM_SET) ? wbits : '0;
  assign unm_clr = (bus_we && slot == SLOT_UNM_CLR) ? wbits : '0;
  assign ack_vec = (bus_we && slot == SLOT_STATUS)  ? wbits : '0;

  irqagg_sync #(.W(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .rise_o  (rise_vec)
  );

  irqagg_bitreg #(.W(NUM_SRC)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .q_o   (en_q)
  );

  irqagg_bitreg #(.W(NUM_SRC)) u_unmask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (unm_set),
    .clr_i (unm_clr),
    .q_o   (unm_q)
  );

  assign cap_vec = rise_vec & en_q;

  irqagg_pend #(.W(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap_vec),
    .ack_i  (ack_vec),
    .pend_o (pend_q)
  );

  assign active_vec = pend_q & en_q & unm_q;

  irqagg_prio #(.W(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .vec_i   (active_vec),
    .valid_o (first_valid),
    .idx_o   (first_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |active_vec;
  end
  assign irq_o = irq_q;

  // Combinational read mux
  always_comb begin
    bus_rdata = '0;
    unique case (slot)
      SLOT_STATUS:               bus_rdata[NUM_SRC-1:0] = pend_q;
      SLOT_EN_SET, SLOT_EN_CLR:  bus_rdata[NUM_SRC-1:0] = en_q;
      SLOT_UNM_SET, SLOT_UNM_CLR: bus_rdata[NUM_SRC-1:0] = unm_q;
      SLOT_FIRST: begin
        bus_rdata[DATA_W-1]  = first_valid;
        bus_rdata[IDX_W-1:0] = first_idx;
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_touch,
  input logic               unm_touch,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] unm_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] cap_vec,
  input logic [NUM_SRC-1:0] ack_vec,
  input logic [NUM_SRC-1:0] active_vec,
  input logic               first_valid,
  input logic [IDX_W-1:0]   first_idx,
  input logic               irq_o
);

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_touch |=> $stable(en_q));

  // R4
  unm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unm_touch |=> $stable(unm_q));

  // R5
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cap_vec)) == '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((pend_q & $past(ack_vec) & ~$past(cap_vec)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_vec & ack_vec) != '0) |=>
      ((pend_q & $past(cap_vec & ack_vec)) == $past(cap_vec & ack_vec)));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(active_vec != '0)));

  // R9
  first_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |-> (active_vec[first_idx] &&
      ((active_vec & ((NUM_SRC'(1) << first_idx) - NUM_SRC'(1))) == '0)));

  // R9
  first_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_valid |-> (active_vec == '0));

endmodule

bind irqagg_top irqagg_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_touch    (en_touch),
  .unm_touch   (unm_touch),
  .en_q        (en_q),
  .unm_q       (unm_q),
  .pend_q      (pend_q),
  .cap_vec     (cap_vec),
  .ack_vec     (ack_vec),
  .active_vec  (active_vec),
  .first_valid (first_valid),
  .first_idx   (first_idx),
  .irq_o       (irq_o)
);

// File: tb/test_irqagg_top.sv
`timescale 1ns/1ps
module test_irqagg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  irqagg_top i_irqagg_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  // Behavioural reference state
  logic [15:0] m_en, m_unm, m_pend;
  logic        m_irq;
  logic [15:0] hist[$];   // hist[0] = latest sampled source word

  function automatic logic [15:0] m_first();
    logic [15:0] act;
    act = m_pend & m_en & m_unm;
    for (int i = 0; i < 16; i++)
      if (act[i]) return 16'h8000 | 16'(i);
    return 16'h0000;
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_pend;
      6'h04, 6'h08: return m_en;
      6'h0C, 6'h10: return m_unm;
      6'h14: return m_first();
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string read_tag(input logic [5:0] a);
    case (a)
      6'h00: return "R6";
      6'h04, 6'h08: return "R2";
      6'h0C, 6'h10: return "R4";
      6'h14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic m_reset();
    m_en = '0; m_unm = '0; m_pend = '0; m_irq = 1'b0;
    hist = '{16'h0, 16'h0, 16'h0};
  endtask

  // One clock of the reference, using the inputs seen at this edge.
  task automatic m_step();
    logic [15:0] rise, ack, nxt;
    rise  = hist[1] & ~hist[2];
    ack   = (we && addr == 6'h00) ? wdata : 16'h0;
    nxt   = (m_pend & ~ack) | (rise & m_en);
    m_irq = ((m_pend & m_en & m_unm) != 0);
    if (we) begin
      case (addr)
        6'h04: m_en  = m_en | wdata;
        6'h08: m_en  = m_en & ~wdata;
        6'h0C: m_unm = m_unm | wdata;
        6'h10: m_unm = m_unm & ~wdata;
        default: ;
      endcase
    end
    m_pend = nxt;
    hist.push_front(src);
    void'(hist.pop_back());
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] srcv = '0;

  task automatic drive(input logic [5:0] a, input logic w, input logic [15:0] d,
                       input bit use_exp, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = w; wdata = d; src = srcv;
    #1;
    if (!w) check(rdata, m_read(a), read_tag(a));
    if (use_exp) check(rdata, exp, tag);
    @(posedge clk);
    m_step();
    #1;
    check({15'd0, irq}, {15'd0, m_irq}, "R8");
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    drive(a, 1'b1, d, 1'b0, 16'h0, "");
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    drive(a, 1'b0, 16'h0, 1'b1, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(6'h3C, 1'b0, 16'h0, 1'b0, 16'h0, "");
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check({15'd0, irq}, 16'h0, "R1");
    rd(6'h00, 16'h0000, "R1");
    rd(6'h04, 16'h0000, "R1");
    rd(6'h0C, 16'h0000, "R1");
    rd(6'h14, 16'h0000, "R1");

    // R2 / R3: enable set and clear
    wr(6'h04, 16'h00FF);
    rd(6'h04, 16'h00FF, "R2");
    wr(6'h04, 16'h0100);
    rd(6'h08, 16'h01FF, "R2");
    wr(6'h08, 16'h0003);
    rd(6'h04, 16'h01FC, "R3");

    // R4: unmask set and mask
    wr(6'h0C, 16'hFFFF);
    wr(6'h10, 16'h00F0);
    rd(6'h10, 16'hFF0F, "R4");

    // R5: rise on source 2 appears two edges after sampling
    srcv = 16'h0004;
    rd(6'h00, 16'h0000, "R5");
    rd(6'h00, 16'h0000, "R5");
    rd(6'h00, 16'h0000, "R5");
    rd(6'h00, 16'h0004, "R5");
    check({15'd0, irq}, 16'h0001, "R8");
    rd(6'h14, 16'h8002, "R9");

    // R5: disabled source 0 captures nothing
    srcv = 16'h0005;
    idle(4);
    rd(6'h00, 16'h0004, "R5");

    // R6: zero write keeps, one write clears
    wr(6'h00, 16'h0000);
    rd(6'h00, 16'h0004, "R6");
    wr(6'h00, 16'h0004);
    rd(6'h00, 16'h0000, "R6");
    check({15'd0, irq}, 16'h0000, "R8");
    idle(3);
    rd(6'h00, 16'h0000, "R5");  // held level is not re-captured

    // R7: capture of source 3 coincides with its acknowledge
    srcv = 16'h000D;
    idle(2);
    wr(6'h00, 16'h0008);
    rd(6'h00, 16'h0008, "R7");

    // R4 / R8 / R9: masking drops the request but keeps status
    wr(6'h10, 16'h0008);
    rd(6'h14, 16'h0000, "R9");
    check({15'd0, irq}, 16'h0000, "R8");
    rd(6'h00, 16'h0008, "R4");

    // R9: lowest active index
    srcv = 16'h010D;
    idle(3);
    rd(6'h00, 16'h0108, "R5");
    rd(6'h14, 16'h8008, "R9");
    wr(6'h0C, 16'h0008);
    rd(6'h14, 16'h8003, "R9");

    // R10: unmapped, misaligned and read-only addresses
    rd(6'h18, 16'h0000, "R10");
    rd(6'h3C, 16'h0000, "R10");
    rd(6'h05, 16'h0000, "R10");
    wr(6'h18, 16'hFFFF);
    wr(6'h14, 16'hFFFF);
    wr(6'h05, 16'hFFFF);
    wr(6'h02, 16'hFFFF);
    rd(6'h04, 16'h01FC, "R10");
    rd(6'h0C, 16'hFF0F, "R10");
    rd(6'h00, 16'h0108, "R10");

    // R8: disabling pending sources drops the request
    wr(6'h08, 16'h0108);
    idle(1);
    check({15'd0, irq}, 16'h0000, "R8");
    rd(6'h00, 16'h0108, "R8");
    rd(6'h14, 16'h0000, "R9");

    // R6: acknowledge everything
    wr(6'h00, 16'hFFFF);
    rd(6'h00, 16'h0000, "R6");
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule